// File: doc/BRIEF.md
# Multiplexed-Bus Glue and Chip-Select Decoder

This block is the glue between a small 8-bit processor and its memories and peripherals. On this processor the low address byte and the data byte share one set of lines. The block captures the address with a latch strobe, so the address stays valid after the shared lines start carrying data. It combines the memory/I-O status line with the read and write strobes to produce four separate active-low command strobes. It decodes the latched address into active-low chip selects for two program-memory banks, two data-memory banks, a parallel-port device and an interrupt-controller device.

Memory selects come from a one-of-eight decode of A14..A12. That decode is enabled only in memory cycles with A15 low, so program memory sits at address zero, where the processor fetches after reset. Peripheral selects come from a second one-of-eight decode, enabled only in I/O cycles. During I/O cycles the 8-bit port number appears on both address bytes, and a parameter chooses which byte is decoded. A second parameter chooses full or partial decoding. Partial decoding leaves some address bits unexamined, so the data banks and the peripherals answer at alias addresses.

Top module: `bus_glue_decoder`

## Requirements
- R1: While `ale` is high, `addr` equals `{addr_hi, ad_bus}`. At each clock edge where `ale` is high that value is captured, and while `ale` is low `addr` holds the last captured value, whatever the shared lines carry.
- R2: With `io_mem` = 0 (memory cycle), `mem_rd_n` follows `rd_n` and `mem_wr_n` follows `wr_n`. With `io_mem` = 1 (I/O cycle), `io_rd_n` follows `rd_n` and `io_wr_n` follows `wr_n`. The strobes of the other space stay high.
- R3: In a memory cycle, `prog_cs_n[0]` is low for addresses 0000H–0FFFH and `prog_cs_n[1]` is low for 1000H–1FFFH, in both decode modes.
- R4: In full-decode mode, `data_cs_n[0]` is low only for 2000H–27FFH and `data_cs_n[1]` only for 3000H–37FFH. At 2800H–2FFFH and 3800H–3FFFH no select is active.
- R5: In partial-decode mode, A11 is ignored for the data banks. `data_cs_n[0]` is low for 2000H–2FFFH and `data_cs_n[1]` for 3000H–3FFFH.
- R6: No memory select is active for addresses 4000H–FFFFH. This covers every address with A15 = 1.
- R7: In an I/O cycle, `port_cs_n` is low for port numbers 40H–43H in full mode and 40H–4FH in partial mode. `port_rs` carries bits 1:0 of the decoded port number.
- R8: In an I/O cycle, `pic_cs_n` is low for port numbers 50H–51H in full mode and 50H–5FH in partial mode. `pic_rs` carries bit 0 of the decoded port number.
- R9: Memory selects are active only in memory cycles, and peripheral selects only in I/O cycles.
- R10: At most one of the six selects is low at any time. All stay high when no range matches.
- R11: While `rst` is high, `addr` is 0000H and every strobe and select is high. The captured address is cleared to 0000H at that clock edge.
- R12: With parameter `IO_FROM_HI` = 0 the port number is taken from `addr[7:0]`; with 1 it is taken from `addr[15:8]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ale | input | 1 | Address latch strobe, active high |
| ad_bus | input | 8 | Shared low-address/data lines |
| addr_hi | input | 8 | Upper address byte |
| io_mem | input | 1 | Cycle status: 1 = I/O, 0 = memory |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | output | 16 | Latched address |
| mem_rd_n | output | 1 | Memory read strobe, active low |
| mem_wr_n | output | 1 | Memory write strobe, active low |
| io_rd_n | output | 1 | I/O read strobe, active low |
| io_wr_n | output | 1 | I/O write strobe, active low |
| prog_cs_n | output | 2 | Program-memory bank selects, active low |
| data_cs_n | output | 2 | Data-memory bank selects, active low |
| port_cs_n | output | 1 | Parallel-port device select, active low |
| pic_cs_n | output | 1 | Interrupt-controller device select, active low |
| port_rs | output | 2 | Parallel-port register select |
| pic_rs | output | 1 | Interrupt-controller register select |

## Verification
The assertions assume that `rd_n` and `wr_n` are never low together, and that `io_mem` and `addr_hi` hold steady through a bus cycle. The hold property also assumes that nothing but `ale` is needed to freeze the address. The stimulus keeps to these assumptions: every bus cycle is an address phase with both strobes high, followed by one data phase that asserts exactly one strobe. In the data phase `io_mem` and the upper byte are unchanged and the shared lines carry an unrelated data value. Every address is swept in memory cycles and every port number in I/O cycles, and one full-mode instance and one partial-mode instance see the same cycles.

// File: rtl/glue_pkg.sv
`timescale 1ns/1ps
package glue_pkg;
   typedef enum logic {
      DEC_PARTIAL = 1'b0,
      DEC_FULL    = 1'b1
   } dec_mode_e;

   typedef struct packed {
      logic mem_rd_n;
      logic mem_wr_n;
      logic io_rd_n;
      logic io_wr_n;
   } strobe_t;

   localparam int ROW_SEL_W = 3;
endpackage

// File: rtl/glue_addr_latch.sv
`timescale 1ns/1ps
module glue_addr_latch #(
   parameter int HI_W = 8,
   parameter int LO_W = 8,
   localparam int AW  = HI_W + LO_W
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            ale,
   input  logic [LO_W-1:0] lo_in,
   input  logic [HI_W-1:0] hi_in,
   output logic [AW-1:0]   addr
);
   logic [AW-1:0] hold_q;

   always_ff @(posedge clk) begin
      if (rst)
         hold_q <= '0;
      else if (ale)
         hold_q <= {hi_in, lo_in};
   end

   // transparent while the strobe is high, frozen once it drops
   always_comb begin
      if (rst)
         addr = '0;
      else if (ale)
         addr = {hi_in, lo_in};
      else
         addr = hold_q;
   end
endmodule

// File: rtl/glue_strobe_gen.sv
`timescale 1ns/1ps
module glue_strobe_gen
   import glue_pkg::*;
(
   input  logic    rst,
   input  logic    io_mem,
   input  logic    rd_n,
   input  logic    wr_n,
   output strobe_t strb
);
   always_comb begin
      strb = '1;
      if (!rst) begin
         if (io_mem) begin
            strb.io_rd_n  = rd_n;
            strb.io_wr_n  = wr_n;
         end else begin
            strb.mem_rd_n = rd_n;
            strb.mem_wr_n = wr_n;
         end
      end
   end
endmodule

// File: rtl/glue_dec_slice.sv
`timescale 1ns/1ps
module glue_dec_slice #(
   parameter int SEL_W = 3,
   parameter int BASE  = 0,
   parameter int N     = 4
) (
   input  logic             en,
   input  logic [SEL_W-1:0] sel,
   output logic [N-1:0]     y_n
);
   localparam int ROWS = 1 << SEL_W;

   initial begin
      if (N < 1 || BASE < 0 || BASE + N > ROWS)
         $fatal(1, "glue_dec_slice: rows %0d..%0d outside decoder", BASE, BASE + N - 1);
   end

   for (genvar i = 0; i < N; i++) begin : g_row
      assign y_n[i] = ~(en && (sel == SEL_W'(BASE + i)));
   end
endmodule

// File: rtl/glue_mem_map.sv
`timescale 1ns/1ps
module glue_mem_map
   import glue_pkg::*;
#(
   parameter dec_mode_e MODE   = DEC_FULL,
   parameter int        N_PROG = 2,
   parameter int        N_DATA = 2,
   localparam int       N_ROW  = N_PROG + N_DATA
) (
   input  logic              rst,
   input  logic              io_mem,
   input  logic [4:0]        a_top,     // A15..A11
   output logic [N_PROG-1:0] prog_cs_n,
   output logic [N_DATA-1:0] data_cs_n
);
   logic [N_ROW-1:0] row_n;
   logic             dec_en;

   initial begin
      if (N_ROW > (1 << ROW_SEL_W))
         $fatal(1, "glue_mem_map: %0d banks exceed decoder rows", N_ROW);
   end

   assign dec_en = !rst && !io_mem && !a_top[4];

   glue_dec_slice #(.SEL_W(ROW_SEL_W), .BASE(0), .N(N_ROW)) u_dec (
      .en  (dec_en),
      .sel (a_top[3:1]),
      .y_n (row_n)
   );

   assign prog_cs_n = row_n[N_PROG-1:0];

   for (genvar j = 0; j < N_DATA; j++) begin : g_data
      if (MODE == DEC_FULL) begin : g_full
         assign data_cs_n[j] = row_n[N_PROG + j] | a_top[0];
      end else begin : g_part
         assign data_cs_n[j] = row_n[N_PROG + j];
      end
   end
endmodule

// File: rtl/glue_io_map.sv
`timescale 1ns/1ps
module glue_io_map
   import glue_pkg::*;
#(
   parameter dec_mode_e MODE = DEC_FULL
) (
   input  logic       rst,
   input  logic       io_mem,
   input  logic [7:0] pnum,
   output logic       port_cs_n,
   output logic       pic_cs_n,
   output logic [1:0] port_rs,
   output logic       pic_rs
);
   localparam int PORT_ROW = 4;   // 40H..4FH
   logic [1:0] row_n;
   logic       dec_en;

   assign dec_en = !rst && io_mem && !pnum[7];

   glue_dec_slice #(.SEL_W(ROW_SEL_W), .BASE(PORT_ROW), .N(2)) u_dec (
      .en  (dec_en),
      .sel (pnum[6:4]),
      .y_n (row_n)
   );

   if (MODE == DEC_FULL) begin : g_full
      assign port_cs_n = row_n[0] | (|pnum[3:2]);
      assign pic_cs_n  = row_n[1] | (|pnum[3:1]);
   end else begin : g_part
      assign port_cs_n = row_n[0];
      assign pic_cs_n  = row_n[1];
   end

   assign port_rs = pnum[1:0];
   assign pic_rs  = pnum[0];
endmodule

// File: rtl/bus_glue_decoder.sv
`timescale 1ns/1ps
module bus_glue_decoder
   import glue_pkg::*;
#(
   parameter int        ADDR_W      = 16,
   parameter dec_mode_e DECODE_MODE = DEC_FULL,
   parameter bit        IO_FROM_HI  = 1'b0,
   localparam int       LO_W        = ADDR_W / 2,
   localparam int       HI_W        = ADDR_W - LO_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ale,
   input  logic [LO_W-1:0]   ad_bus,
   input  logic [HI_W-1:0]   addr_hi,
   input  logic              io_mem,
   input  logic              rd_n,
   input  logic              wr_n,
   output logic [ADDR_W-1:0] addr,
   output logic              mem_rd_n,
   output logic              mem_wr_n,
   output logic              io_rd_n,
   output logic              io_wr_n,
   output logic [1:0]        prog_cs_n,
   output logic [1:0]        data_cs_n,
   output logic              port_cs_n,
   output logic              pic_cs_n,
   output logic [1:0]        port_rs,
   output logic              pic_rs
);
   initial begin
      if (ADDR_W != 16)
         $fatal(1, "bus_glue_decoder: memory map needs a 16-bit address, got %0d", ADDR_W);
   end

   strobe_t    strb;
   logic [7:0] pnum;

   glue_addr_latch #(.HI_W(HI_W), .LO_W(LO_W)) u_latch (
      .clk   (clk),
      .rst   (rst),
      .ale   (ale),
      .lo_in (ad_bus),
      .hi_in (addr_hi),
      .addr  (addr)
   );

   glue_strobe_gen u_strb (
      .rst    (rst),
      .io_mem (io_mem),
      .rd_n   (rd_n),
      .wr_n   (wr_n),
      .strb   (strb)
   );

   assign mem_rd_n = strb.mem_rd_n;
   assign mem_wr_n = strb.mem_wr_n;
   assign io_rd_n  = strb.io_rd_n;
   assign io_wr_n  = strb.io_wr_n;

   glue_mem_map #(.MODE(DECODE_MODE), .N_PROG(2), .N_DATA(2)) u_mem (
      .rst       (rst),
      .io_mem    (io_mem),
      .a_top     (addr[ADDR_W-1 -: 5]),
      .prog_cs_n (prog_cs_n),
      .data_cs_n (data_cs_n)
   );

   if (IO_FROM_HI) begin : g_io_hi
      assign pnum = addr[ADDR_W-1 -: 8];
   end else begin : g_io_lo
      assign pnum = addr[7:0];
   end

   glue_io_map #(.MODE(DECODE_MODE)) u_io (
      .rst       (rst),
      .io_mem    (io_mem),
      .pnum      (pnum),
      .port_cs_n (port_cs_n),
      .pic_cs_n  (pic_cs_n),
      .port_rs   (port_rs),
      .pic_rs    (pic_rs)
   );
endmodule

module glue_chk #(
   parameter int ADDR_W = 16
) (
   input logic              clk,
   input logic              rst,
   input logic              ale,
   input logic [ADDR_W/2-1:0] ad_bus,
   input logic [ADDR_W-ADDR_W/2-1:0] addr_hi,
   input logic              io_mem,
   input logic [ADDR_W-1:0] addr,
   input logic              mem_rd_n,
   input logic              mem_wr_n,
   input logic              io_rd_n,
   input logic              io_wr_n,
   input logic [1:0]        prog_cs_n,
   input logic [1:0]        data_cs_n,
   input logic              port_cs_n,
   input logic              pic_cs_n
);
   logic [5:0] sel_on;
   assign sel_on = ~{pic_cs_n, port_cs_n, data_cs_n, prog_cs_n};

   a_r1_capture_on_fall: assert property (@(posedge clk) disable iff (rst)
      ($fell(ale) && !$past(rst)) |-> (addr == $past({addr_hi, ad_bus})));

   a_r1_hold_while_low: assert property (@(posedge clk) disable iff (rst)
      (!ale && !$past(ale) && !$past(rst)) |-> $stable(addr));

   a_r2_mem_quiet_in_io: assert property (@(posedge clk) disable iff (rst)
      io_mem |-> (mem_rd_n && mem_wr_n));

   a_r2_io_quiet_in_mem: assert property (@(posedge clk) disable iff (rst)
      !io_mem |-> (io_rd_n && io_wr_n));

   a_r3_reset_vector: assert property (@(posedge clk) disable iff (rst)
      (!io_mem && addr[ADDR_W-1 -: 4] == 4'h0) |-> !prog_cs_n[0]);

   a_r6_upper_half_idle: assert property (@(posedge clk) disable iff (rst)
      (!io_mem && addr[ADDR_W-1]) |-> (&{prog_cs_n, data_cs_n}));

   a_r9_no_mem_cs_in_io: assert property (@(posedge clk) disable iff (rst)
      io_mem |-> (&{prog_cs_n, data_cs_n}));

   a_r9_no_io_cs_in_mem: assert property (@(posedge clk) disable iff (rst)
      !io_mem |-> (port_cs_n && pic_cs_n));

   a_r10_single_select: assert property (@(posedge clk) disable iff (rst)
      $onehot0(sel_on));

   a_r11_reset_quiet: assert property (@(posedge clk)
      rst |-> (addr == '0 && sel_on == '0 && mem_rd_n && mem_wr_n && io_rd_n && io_wr_n));
endmodule

bind bus_glue_decoder glue_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .ale       (ale),
   .ad_bus    (ad_bus),
   .addr_hi   (addr_hi),
   .io_mem    (io_mem),
   .addr      (addr),
   .mem_rd_n  (mem_rd_n),
   .mem_wr_n  (mem_wr_n),
   .io_rd_n   (io_rd_n),
   .io_wr_n   (io_wr_n),
   .prog_cs_n (prog_cs_n),
   .data_cs_n (data_cs_n),
   .port_cs_n (port_cs_n),
   .pic_cs_n  (pic_cs_n)
);

// File: tb/sim_bus_glue_decoder.sv
`timescale 1ns/1ps
module sim_bus_glue_decoder;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       ale = 1'b0;
   logic [7:0] ad_bus = 8'h00;
   logic [7:0] addr_hi = 8'h00;
   logic       io_mem = 1'b0;
   logic       rd_n = 1'b1;
   logic       wr_n = 1'b1;

   always #2.5 clk = ~clk;

   // instance 0: full decode, port number from low byte
   logic [15:0] a0;
   logic        mr0, mw0, ir0, iw0, pt0, pc0, prs0;
   logic [1:0]  pg0, dt0, rs0;
   // instance 1: partial decode, port number from high byte
   logic [15:0] a1;
   logic        mr1, mw1, ir1, iw1, pt1, pc1, prs1;
   logic [1:0]  pg1, dt1, rs1;

   bus_glue_decoder #(.DECODE_MODE(glue_pkg::DEC_FULL), .IO_FROM_HI(1'b0)) u0 (
      .clk(clk), .rst(rst), .ale(ale), .ad_bus(ad_bus), .addr_hi(addr_hi),
      .io_mem(io_mem), .rd_n(rd_n), .wr_n(wr_n), .addr(a0),
      .mem_rd_n(mr0), .mem_wr_n(mw0), .io_rd_n(ir0), .io_wr_n(iw0),
      .prog_cs_n(pg0), .data_cs_n(dt0), .port_cs_n(pt0), .pic_cs_n(pc0),
      .port_rs(rs0), .pic_rs(prs0));

   bus_glue_decoder #(.DECODE_MODE(glue_pkg::DEC_PARTIAL), .IO_FROM_HI(1'b1)) u1 (
      .clk(clk), .rst(rst), .ale(ale), .ad_bus(ad_bus), .addr_hi(addr_hi),
      .io_mem(io_mem), .rd_n(rd_n), .wr_n(wr_n), .addr(a1),
      .mem_rd_n(mr1), .mem_wr_n(mw1), .io_rd_n(ir1), .io_wr_n(iw1),
      .prog_cs_n(pg1), .data_cs_n(dt1), .port_cs_n(pt1), .pic_cs_n(pc1),
      .port_rs(rs1), .pic_rs(prs1));

   int          n_chk  = 0;
   int          n_fail = 0;
   bit          done   = 1'b0;
   logic [15:0] ref_hold = 16'h0000;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
      end
   endtask

   // expected selects, active high: {pic, port, data2, data1, prog2, prog1}
   function automatic logic [5:0] exp_sel(input logic [15:0] a, input logic io,
                                          input bit full, input bit from_hi);
      int v;
      int p;
      logic [5:0] s;
      s = 6'b0;
      v = int'(a);
      p = from_hi ? int'(a[15:8]) : int'(a[7:0]);
      if (!io) begin
         if (v < 'h1000)                          s[0] = 1'b1;
         else if (v < 'h2000)                     s[1] = 1'b1;
         else if (v < (full ? 'h2800 : 'h3000))   s[2] = 1'b1;
         else if (v >= 'h3000 && v < (full ? 'h3800 : 'h4000)) s[3] = 1'b1;
      end else begin
         if (p >= 'h40 && p <= (full ? 'h43 : 'h4F))      s[4] = 1'b1;
         else if (p >= 'h50 && p <= (full ? 'h51 : 'h5F)) s[5] = 1'b1;
      end
      return s;
   endfunction

   function automatic string sel_tag(input logic [15:0] a, input logic io,
                                     input bit full, input bit from_hi);
      int p;
      p = from_hi ? int'(a[15:8]) : int'(a[7:0]);
      if (io) return (p[4] ? "R8 pic select" : "R7 port select");
      if (a < 16'h2000) return "R3 program select";
      if (a >= 16'h4000) return "R6 upper memory idle";
      return full ? "R4 data select full" : "R5 data select partial";
   endfunction

   task automatic check_one(input string who, input bit full, input bit from_hi,
                            input logic [15:0] act_a, input logic [3:0] act_st,
                            input logic [5:0] act_sel, input logic [2:0] act_rs,
                            input logic [15:0] exp_a, input logic [3:0] exp_st);
      logic [5:0] es;
      logic [7:0] pb;
      es = rst ? 6'b0 : exp_sel(exp_a, io_mem, full, from_hi);
      pb = from_hi ? exp_a[15:8] : exp_a[7:0];
      chk({who, (rst ? " R11 reset address" : " R1 latched address")}, 32'(act_a), 32'(exp_a));
      chk({who, (rst ? " R11 reset strobes" : " R2 strobes")}, 32'(act_st), 32'(exp_st));
      chk({who, " ", (rst ? "R11 reset selects" : sel_tag(exp_a, io_mem, full, from_hi))},
          32'(act_sel), 32'(es));
      chk({who, " R10 at most one select"}, 32'($countones(act_sel) <= 1), 32'd1);
      chk({who, " R9 select space"}, 32'(io_mem ? act_sel[3:0] : act_sel[5:4]), 32'd0);
      chk({who, " R12 register selects from decoded byte"}, 32'(act_rs), 32'({pb[1:0], pb[0]}));
   endtask

   task automatic step(input logic s_ale, input logic [7:0] lo, input logic [7:0] hi,
                       input logic io, input logic rdn, input logic wrn, input logic r);
      logic [15:0] ea;
      logic [3:0]  est;
      ale = s_ale; ad_bus = lo; addr_hi = hi; io_mem = io; rd_n = rdn; wr_n = wrn; rst = r;
      @(negedge clk);
      ea  = r ? 16'h0000 : (s_ale ? {hi, lo} : ref_hold);
      est = r ? 4'b0000 : {!io && !rdn, !io && !wrn, io && !rdn, io && !wrn};
      check_one("u0", 1'b1, 1'b0, a0, ~{mr0, mw0, ir0, iw0},
                ~{pc0, pt0, dt0, pg0}, {rs0, prs0}, ea, est);
      check_one("u1", 1'b0, 1'b1, a1, ~{mr1, mw1, ir1, iw1},
                ~{pc1, pt1, dt1, pg1}, {rs1, prs1}, ea, est);
      @(posedge clk);
      if (r) ref_hold = 16'h0000;
      else if (s_ale) ref_hold = {hi, lo};
      #1;
   endtask

   initial begin
      // R11: reset forces everything quiet even with active inputs
      step(1'b1, 8'hFF, 8'h12, 1'b0, 1'b0, 1'b1, 1'b1);
      step(1'b0, 8'h34, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1);
      step(1'b1, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1);
      // R1: capture, then hold while the shared lines carry data
      step(1'b1, 8'h34, 8'h12, 1'b0, 1'b1, 1'b1, 1'b0);
      step(1'b0, 8'hAB, 8'h12, 1'b0, 1'b0, 1'b1, 1'b0);
      step(1'b0, 8'hCD, 8'h12, 1'b0, 1'b1, 1'b0, 1'b0);
      // R2: each strobe combination in each space
      step(1'b1, 8'h42, 8'h42, 1'b1, 1'b1, 1'b1, 1'b0);
      step(1'b0, 8'h99, 8'h42, 1'b1, 1'b0, 1'b1, 1'b0);
      step(1'b0, 8'h98, 8'h42, 1'b1, 1'b1, 1'b0, 1'b0);
      // R3..R6, R9, R10: every memory address, read or write data phase
      for (int a = 0; a < 65536; a++) begin
         logic [15:0] av;
         av = 16'(a);
         step(1'b1, av[7:0], av[15:8], 1'b0, 1'b1, 1'b1, 1'b0);
         step(1'b0, av[7:0] ^ 8'h5A, av[15:8], 1'b0, av[0], ~av[0], 1'b0);
      end
      // R7, R8, R9: every port number, duplicated on both bytes
      for (int p = 0; p < 256; p++) begin
         logic [7:0] pv;
         pv = 8'(p);
         step(1'b1, pv, pv, 1'b1, 1'b1, 1'b1, 1'b0);
         step(1'b0, ~pv, pv, 1'b1, pv[0], ~pv[0], 1'b0);
      end
      // R12: bytes differ, so the decode source shows
      step(1'b1, 8'h40, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0);
      step(1'b1, 8'h00, 8'h50, 1'b1, 1'b1, 1'b1, 1'b0);
      step(1'b1, 8'h51, 8'h43, 1'b1, 1'b0, 1'b1, 1'b0);
      // R11: reset mid-run clears the captured address
      step(1'b1, 8'h00, 8'h30, 1'b0, 1'b1, 1'b1, 1'b0);
      step(1'b0, 8'h11, 8'h30, 1'b0, 1'b0, 1'b1, 1'b1);
      step(1'b0, 8'h22, 8'h30, 1'b0, 1'b0, 1'b1, 1'b0);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule